// File: doc/BRIEF.md
# Indirect Register Pointer Interface

This block is the bus-side front end of a peripheral whose 64 internal byte registers are all reached through one byte-wide control port. Software first writes a register number to the port, and the access that follows carries the data byte for that register. The front end keeps track of which of the two steps comes next and turns the data step into a one-cycle read or write strobe toward the register file. It also holds the two master registers itself: the master interrupt control register at address 0x00 and the master configuration register at address 0x01.

Bit 0 of the master interrupt control register is the device reset. While it is set, the whole device is held in reset, every enable is forced low and the pointer machine stays in its idle (pointer) step. Because software cannot tell which step the port expects, a fixed six-access sequence is defined that leaves the port idle and out of reset no matter where it started: read, write 0, read, write 0, write 1, write 0. A bus access is one cycle with `acc_valid` high. Read data appears on `acc_rdata` from the clock edge that accepts the read.

Top module: `ipi_top`

## Requirements
- R1: After `rst_n` is released, `dev_reset` is 1, all seven enable outputs are 0, the port is in its pointer step, and no register file strobe is issued.
- R2: A write in the pointer step loads only bits 5:0 of the written byte as the register address, which appears on `rf_addr` after that edge, and moves the port to its data step. An address of 63 is valid.
- R3: A read in the data step returns the addressed register's byte on `acc_rdata` from the accepting edge onward, raises `rf_rd_en` for that cycle when the address is 2 or higher, and returns the port to its pointer step.
- R4: A write in the data step to an address of 2 or higher raises `rf_wr_en` for that cycle with `rf_addr` and `rf_wdata` holding the address and byte, and returns the port to its pointer step.
- R5: A read in the pointer step does not advance the port and returns the byte 0x00, or 0x01 while the device is held in reset.
- R6: In register 0x00, bit 7 drives `irq_master_en` and bit 6 drives `irq_lower_chain_dis`. A data-step write with bit 0 clear stores the whole byte, and a later data-step read returns it.
- R7: In register 0x01, bit 7 drives `en_port_b`, bit 6 `en_ch1`, bit 5 `en_ch2`, bit 4 `en_port_c_ch3` and bit 2 `en_port_a`. The whole byte is stored and reads back.
- R8: A data-step write to register 0x00 with bit 0 set puts the device in reset. In the same edge it clears every other bit of registers 0x00 and 0x01 and returns the port to its pointer step, so the very next write is handled as a write made under reset.
- R9: While `dev_reset` is 1, a write with bit 0 set is ignored and loads no address. A write with bit 0 clear releases reset, leaves every other bit of both master registers at 0, and leaves the port in its pointer step. No register file strobe is issued while `dev_reset` is 1.
- R10: The sequence read, write 0x00, read, write 0x00, write 0x01, write 0x00 ends with `dev_reset` at 0 and the port in its pointer step, whether it starts in the pointer step, the data step or reset.
- R11: Data-step accesses to addresses 0x00 and 0x01 never raise `rf_wr_en` or `rf_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One bus access on the control port this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_wdata | input | 8 | Byte written to the control port |
| acc_rdata | output | 8 | Byte returned by the last read access |
| rf_addr | output | 6 | Current register address (pointer) |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_rd_en | output | 1 | Register file read strobe |
| rf_wdata | output | 8 | Register file write data |
| rf_rdata | input | 8 | Register file read data at `rf_addr` |
| dev_reset | output | 1 | Device held in reset |
| irq_master_en | output | 1 | Master interrupt enable |
| irq_lower_chain_dis | output | 1 | Disable lower interrupt chain |
| en_port_a | output | 1 | Port A enable |
| en_port_b | output | 1 | Port B enable |
| en_port_c_ch3 | output | 1 | Port C and channel 3 enable |
| en_ch1 | output | 1 | Channel 1 enable |
| en_ch2 | output | 1 | Channel 2 enable |

## Verification
Two things happen in the same clock edge: the data-step write that sets the reset bit, and the return of the pointer machine to its idle step. The bench sets up live enables, writes 0xC1 to register 0x00, and then sends 0x07 straight after it. If the two steps were not settled together, that byte would load an address or store data. The check requires instead that it is ignored: reset stays held, the address stays 0, the idle read gives 0x01, and both master registers read 0 after the release write.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  localparam int MIC_ADDR = 0;
  localparam int MCC_ADDR = 1;

  localparam int MIC_RST_BIT = 0;
  localparam int MIC_DLC_BIT = 6;
  localparam int MIC_MIE_BIT = 7;

  localparam int MCC_PAE_BIT = 2;
  localparam int MCC_PCE_BIT = 4;
  localparam int MCC_C2E_BIT = 5;
  localparam int MCC_C1E_BIT = 6;
  localparam int MCC_PBE_BIT = 7;

  typedef enum logic {
    PH_PTR  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

endpackage

// File: rtl/ipi_ptr_fsm.sv
module ipi_ptr_fsm
  import ipi_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          hold,
  output logic          data_phase,
  output logic [AW-1:0] ptr_q
);

  phase_e        phase_q;
  phase_e        phase_d;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    phase_d = phase_q;
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    if (hold) begin
      phase_d = PH_PTR;
    end else if (acc_valid) begin
      case (phase_q)
        PH_PTR: begin
          if (acc_write) begin
            phase_d = PH_DATA;
            ptr_d   = ptr_wdata;
            ptr_en  = 1'b1;
          end
        end
        PH_DATA: phase_d = PH_PTR;
        default: phase_d = PH_PTR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PTR;
      ptr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  assign data_phase = (phase_q == PH_DATA);

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && phase_q == PH_PTR && !hold)
      |=> (phase_q == PH_DATA && ptr_q == $past(ptr_wdata))); // R2

  AST_DATA_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && phase_q == PH_DATA) |=> (phase_q == PH_PTR)); // R3

  AST_IDLE_READ_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && phase_q == PH_PTR) |=> (phase_q == PH_PTR)); // R5

  AST_HOLD_IN_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (phase_q == PH_PTR)); // R9

endmodule

// File: rtl/ipi_mstr_regs.sv
module ipi_mstr_regs
  import ipi_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [DW-1:0] acc_wdata,
  input  logic          wr_mic,
  input  logic          wr_mcc,
  output logic [DW-1:0] mic_q,
  output logic [DW-1:0] mcc_q,
  output logic          hold
);

  localparam logic [DW-1:0] MIC_RST_VAL = DW'(1) << MIC_RST_BIT;

  logic [DW-1:0] mic_d;
  logic [DW-1:0] mcc_d;
  logic          mic_en;
  logic          mcc_en;

  assign hold = mic_q[MIC_RST_BIT];

  always_comb begin
    mic_d  = mic_q;
    mcc_d  = mcc_q;
    mic_en = 1'b0;
    mcc_en = 1'b0;
    if (hold) begin
      if (acc_valid && acc_write && !acc_wdata[MIC_RST_BIT]) begin
        mic_d  = '0;
        mic_en = 1'b1;
      end
    end else if (wr_mic) begin
      mic_en = 1'b1;
      if (acc_wdata[MIC_RST_BIT]) begin
        mic_d  = MIC_RST_VAL;
        mcc_d  = '0;
        mcc_en = 1'b1;
      end else begin
        mic_d  = acc_wdata;
      end
    end else if (wr_mcc) begin
      mcc_d  = acc_wdata;
      mcc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mic_q <= MIC_RST_VAL;
      mcc_q <= '0;
    end else begin
      if (mic_en) mic_q <= mic_d;
      if (mcc_en) mcc_q <= mcc_d;
    end
  end

  AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (mcc_q == '0 && mic_q[DW-1:1] == '0)); // R9

  AST_RELEASE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(acc_valid && acc_write && !acc_wdata[MIC_RST_BIT])); // R9

  AST_SET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mic && acc_wdata[MIC_RST_BIT]) |=> (hold && mcc_q == '0)); // R8

endmodule

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          data_phase,
  input  logic          hold,
  input  logic [AW-1:0] ptr_q,
  input  logic [DW-1:0] mic_q,
  input  logic [DW-1:0] mcc_q,
  input  logic [DW-1:0] rf_rdata,
  output logic          wr_mic,
  output logic          wr_mcc,
  output logic          rf_wr_en,
  output logic          rf_rd_en,
  output logic [DW-1:0] rd_q
);

  logic          data_acc;
  logic          is_mic;
  logic          is_mcc;
  logic          is_file;
  logic [DW-1:0] rd_d;
  logic          rd_en;

  assign data_acc = acc_valid && data_phase && !hold;
  assign is_mic   = (ptr_q == AW'(MIC_ADDR));
  assign is_mcc   = (ptr_q == AW'(MCC_ADDR));
  assign is_file  = !is_mic && !is_mcc;

  assign wr_mic   = data_acc && acc_write && is_mic;
  assign wr_mcc   = data_acc && acc_write && is_mcc;
  assign rf_wr_en = data_acc && acc_write && is_file;
  assign rf_rd_en = data_acc && !acc_write && is_file;

  always_comb begin
    rd_en = acc_valid && !acc_write;
    if (!data_acc) begin
      rd_d = {{(DW-1){1'b0}}, hold};
    end else if (is_mic) begin
      rd_d = mic_q;
    end else if (is_mcc) begin
      rd_d = mcc_q;
    end else begin
      rd_d = rf_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  AST_RD_HELD_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && hold) |=> (rd_q == DW'(1))); // R5

endmodule

// File: rtl/ipi_top.sv
module ipi_top
  import ipi_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic [AW-1:0] rf_addr,
  output logic          rf_wr_en,
  output logic          rf_rd_en,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata,
  output logic          dev_reset,
  output logic          irq_master_en,
  output logic          irq_lower_chain_dis,
  output logic          en_port_a,
  output logic          en_port_b,
  output logic          en_port_c_ch3,
  output logic          en_ch1,
  output logic          en_ch2
);

  logic          hold;
  logic          data_phase;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] mic_q;
  logic [DW-1:0] mcc_q;
  logic          wr_mic;
  logic          wr_mcc;

  ipi_ptr_fsm #(.AW(AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .ptr_wdata  (acc_wdata[AW-1:0]),
    .hold       (hold),
    .data_phase (data_phase),
    .ptr_q      (ptr_q)
  );

  ipi_mstr_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_wdata (acc_wdata),
    .wr_mic    (wr_mic),
    .wr_mcc    (wr_mcc),
    .mic_q     (mic_q),
    .mcc_q     (mcc_q),
    .hold      (hold)
  );

  ipi_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .data_phase (data_phase),
    .hold       (hold),
    .ptr_q      (ptr_q),
    .mic_q      (mic_q),
    .mcc_q      (mcc_q),
    .rf_rdata   (rf_rdata),
    .wr_mic     (wr_mic),
    .wr_mcc     (wr_mcc),
    .rf_wr_en   (rf_wr_en),
    .rf_rd_en   (rf_rd_en),
    .rd_q       (acc_rdata)
  );

  assign rf_addr             = ptr_q;
  assign rf_wdata            = acc_wdata;
  assign dev_reset           = hold;
  assign irq_master_en       = mic_q[MIC_MIE_BIT];
  assign irq_lower_chain_dis = mic_q[MIC_DLC_BIT];
  assign en_port_a           = mcc_q[MCC_PAE_BIT];
  assign en_port_b           = mcc_q[MCC_PBE_BIT];
  assign en_port_c_ch3       = mcc_q[MCC_PCE_BIT];
  assign en_ch1              = mcc_q[MCC_C1E_BIT];
  assign en_ch2              = mcc_q[MCC_C2E_BIT];

  AST_NO_FILE_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> (!rf_wr_en && !rf_rd_en)); // R9

  AST_ENABLES_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> !(irq_master_en || en_port_a || en_port_b || en_ch1 || en_ch2)); // R1

endmodule

// File: tb/ipi_top_tb_top.sv
`timescale 1ns/1ps
module ipi_top_tb_top;

  logic       clk;
  logic       rst_n;
  logic       acc_valid;
  logic       acc_write;
  logic [7:0] acc_wdata;
  logic [7:0] acc_rdata;
  logic [5:0] rf_addr;
  logic       rf_wr_en;
  logic       rf_rd_en;
  logic [7:0] rf_wdata;
  logic [7:0] rf_rdata;
  logic       dev_reset;
  logic       irq_master_en;
  logic       irq_lower_chain_dis;
  logic       en_port_a;
  logic       en_port_b;
  logic       en_port_c_ch3;
  logic       en_ch1;
  logic       en_ch2;

  int n_checks;
  int n_fail;
  int rf_wr_cnt;
  int rf_rd_cnt;
  bit done;
  logic [7:0] rf_mem [64];

  ipi_top dut_i (
    .clk                 (clk),
    .rst_n               (rst_n),
    .acc_valid           (acc_valid),
    .acc_write           (acc_write),
    .acc_wdata           (acc_wdata),
    .acc_rdata           (acc_rdata),
    .rf_addr             (rf_addr),
    .rf_wr_en            (rf_wr_en),
    .rf_rd_en            (rf_rd_en),
    .rf_wdata            (rf_wdata),
    .rf_rdata            (rf_rdata),
    .dev_reset           (dev_reset),
    .irq_master_en       (irq_master_en),
    .irq_lower_chain_dis (irq_lower_chain_dis),
    .en_port_a           (en_port_a),
    .en_port_b           (en_port_b),
    .en_port_c_ch3       (en_port_c_ch3),
    .en_ch1              (en_ch1),
    .en_ch2              (en_ch2)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign rf_rdata = rf_mem[rf_addr];

  always @(posedge clk) begin
    if (rf_wr_en) begin
      rf_mem[rf_addr] <= rf_wdata;
      rf_wr_cnt <= rf_wr_cnt + 1;
    end
    if (rf_rd_en) rf_rd_cnt <= rf_rd_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int enables();
    return {irq_master_en, irq_lower_chain_dis, en_port_b, en_ch1,
            en_ch2, en_port_c_ch3, en_port_a};
  endfunction

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = 1'b1;
    acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic do_rd(output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
    d = acc_rdata;
  endtask

  task automatic recover_seq();
    logic [7:0] tmp;
    do_rd(tmp);
    do_wr(8'h00);
    do_rd(tmp);
    do_wr(8'h00);
    do_wr(8'h01);
    do_wr(8'h00);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    chk("R1 dev_reset after rst_n", dev_reset, 1);
    chk("R1 enables after rst_n", enables(), 0);
    do_rd(d);
    chk("R1 idle read under reset", d, 8'h01);
    chk("R1 no strobes", rf_wr_cnt + rf_rd_cnt, 0);
  endtask

  task automatic t_held_writes();
    do_wr(8'h05);
    chk("R9 bit0 write ignored, reset held", dev_reset, 1);
    chk("R9 no address loaded", rf_addr, 0);
    do_wr(8'h80);
    chk("R9 release write clears reset", dev_reset, 0);
    chk("R9 other bits stay 0", enables(), 0);
    chk("R9 no strobes while held", rf_wr_cnt + rf_rd_cnt, 0);
  endtask

  task automatic t_idle_read();
    logic [7:0] d;
    do_rd(d);
    chk("R5 idle read value", d, 8'h00);
    do_wr(8'h02);
    chk("R5 read did not advance (pointer loaded)", rf_addr, 2);
    chk("R5 no file write", rf_wr_cnt, 0);
  endtask

  task automatic t_file_access();
    logic [7:0] d;
    int rd0;
    do_wr(8'hA5);
    chk("R4 file write strobe", rf_wr_cnt, 1);
    chk("R4 file content", rf_mem[2], 8'hA5);
    rd0 = rf_rd_cnt;
    do_wr(8'h02);
    do_rd(d);
    chk("R3 read data", d, 8'hA5);
    chk("R3 read strobe", rf_rd_cnt, rd0 + 1);
    do_wr(8'h0B);
    chk("R3 back to pointer step", rf_addr, 11);
    chk("R3 no write after read", rf_wr_cnt, 1);
    do_wr(8'h00);
  endtask

  task automatic t_addr_mask();
    logic [7:0] d;
    do_wr(8'hC7);
    chk("R2 low 6 bits used", rf_addr, 7);
    do_wr(8'h3C);
    do_wr(8'h07);
    do_rd(d);
    chk("R2 masked address data", d, 8'h3C);
    do_wr(8'h3F);
    chk("R2 top address", rf_addr, 63);
    do_wr(8'h99);
    do_wr(8'hFF);
    do_rd(d);
    chk("R2 top address data", d, 8'h99);
  endtask

  task automatic t_mic_fields();
    logic [7:0] d;
    int wc;
    int rc;
    wc = rf_wr_cnt;
    rc = rf_rd_cnt;
    do_wr(8'h00);
    do_wr(8'hC0);
    chk("R6 irq_master_en", irq_master_en, 1);
    chk("R6 irq_lower_chain_dis", irq_lower_chain_dis, 1);
    chk("R6 no reset", dev_reset, 0);
    do_wr(8'h00);
    do_rd(d);
    chk("R6 readback", d, 8'hC0);
    chk("R11 no strobe for reg 0", (rf_wr_cnt - wc) + (rf_rd_cnt - rc), 0);
  endtask

  task automatic t_mcc_fields();
    logic [7:0] d;
    int wc;
    int rc;
    wc = rf_wr_cnt;
    rc = rf_rd_cnt;
    do_wr(8'h01);
    do_wr(8'hF4);
    chk("R7 all five enables", {en_port_b, en_ch1, en_ch2, en_port_c_ch3, en_port_a}, 5'h1F);
    do_wr(8'h01);
    do_wr(8'h84);
    chk("R7 port B and A only", {en_port_b, en_ch1, en_ch2, en_port_c_ch3, en_port_a}, 5'b10001);
    do_wr(8'h01);
    do_rd(d);
    chk("R7 readback", d, 8'h84);
    chk("R11 no strobe for reg 1", (rf_wr_cnt - wc) + (rf_rd_cnt - rc), 0);
  endtask

  task automatic t_reset_collision();
    logic [7:0] d;
    do_wr(8'h00);
    do_wr(8'hC1);
    chk("R8 reset set", dev_reset, 1);
    chk("R8 enables cleared", enables(), 0);
    do_wr(8'h07);
    chk("R8 next write under reset ignored", dev_reset, 1);
    chk("R8 next write loads no address", rf_addr, 0);
    do_rd(d);
    chk("R5 idle read in reset", d, 8'h01);
    do_wr(8'h00);
    chk("R9 released", dev_reset, 0);
    do_wr(8'h01);
    do_rd(d);
    chk("R9 reg 1 cleared", d, 8'h00);
    do_wr(8'h00);
    do_rd(d);
    chk("R9 reg 0 cleared", d, 8'h00);
  endtask

  task automatic t_recover_from_data();
    int wc;
    do_wr(8'h05);
    recover_seq();
    chk("R10 out of reset (from data step)", dev_reset, 0);
    wc = rf_wr_cnt;
    do_wr(8'h09);
    chk("R10 pointer step after sequence", rf_addr, 9);
    chk("R10 no file write", rf_wr_cnt, wc);
    do_wr(8'h11);
  endtask

  task automatic t_recover_from_idle();
    do_wr(8'h01);
    do_wr(8'h10);
    chk("R7 port C/ch3 enable", en_port_c_ch3, 1);
    recover_seq();
    chk("R10 out of reset (from pointer step)", dev_reset, 0);
    chk("R10 enables cleared by sequence", en_port_c_ch3, 0);
    do_wr(8'h0C);
    chk("R10 pointer step after idle start", rf_addr, 12);
    do_wr(8'h00);
  endtask

  task automatic t_recover_from_reset();
    do_wr(8'h00);
    do_wr(8'h01);
    recover_seq();
    chk("R10 out of reset (from reset)", dev_reset, 0);
    do_wr(8'h0D);
    chk("R10 pointer step after reset start", rf_addr, 13);
  endtask

  initial begin
    n_checks  = 0;
    n_fail    = 0;
    rf_wr_cnt = 0;
    rf_rd_cnt = 0;
    done      = 1'b0;
    for (int i = 0; i < 64; i++) rf_mem[i] = 8'h00;
    acc_valid = 1'b0;
    acc_write = 1'b0;
    acc_wdata = 8'h00;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_held_writes();
    t_idle_read();
    t_file_access();
    t_addr_mask();
    t_mic_fields();
    t_mcc_fields();
    t_reset_collision();
    t_recover_from_data();
    t_recover_from_idle();
    t_recover_from_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule